// File: doc/BRIEF.md
# Reset-Time Boot Block Copier

This block runs while the processor is held in reset. It reads a fixed-size block of boot code, one byte at a time, from a peripheral register whose read pointer advances on every access. It packs the bytes into 16-bit words and writes them to DRAM starting at address zero. When the last word has been accepted, the block releases the processor's reset and halt lines, so the first instruction fetch, from address 0, finds the copied code.

On the byte-wide peripheral bus the block first writes the register index that selects the flash data register, once. It then issues a series of data reads. Every bus transaction and every DRAM write is a request that stays in place until the responder acknowledges it, so the block works with any number of wait states.

An inhibit flag, which software sets in the peripheral, is sampled in the first clock after reset is released. When the flag is set, the block skips the copy and releases the processor at once. A reset during a copy starts the whole sequence again.

Top module: `boot_copier`

## Requirements
- R1: After reset is released with the inhibit flag low, the first bus transaction is exactly one write (`bus_we_o`=1) of index value 0x00 to address 0xF00001, and it occurs before any data read.
- R2: After the index write, the block performs exactly 512 bus reads, all at address 0xF00000, each completed by one cycle with `bus_ack_i` high.
- R3: Source byte 2k is placed in bits [15:8] and byte 2k+1 in bits [7:0] of the word written at byte address 2k. The 256 DRAM writes go in ascending address order, from 0 to 510.
- R4: `cpu_reset_n_o` and `cpu_halt_n_o` stay low until `done_o` is set. `done_o` becomes high at the clock edge that accepts the 256th DRAM write, and not earlier.
- R5: While `done_o` is high, `bus_cyc_o` and `mem_wr_o` are low. No bus or DRAM request is made while the processor is released.
- R6: Once set, `done_o` stays high until the next reset.
- R7: A bus request or a DRAM write request holds its address, direction and data unchanged until it is acknowledged, for any number of wait cycles.
- R8: If `inhibit_i` is high at the first clock edge after reset is released, no bus or DRAM request is made, and `done_o` rises at that same edge.
- R9: While reset is asserted, `done_o`, `bus_cyc_o` and `mem_wr_o` are low and the processor is held. A reset asserted in the middle of a copy makes the next copy restart from the index write and DRAM address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts a new copy |
| inhibit_i | input | 1 | Skip-copy flag set by software in the peripheral |
| bus_cyc_o | output | 1 | Peripheral bus request active |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 24 | Peripheral bus address |
| bus_wdata_o | output | 8 | Write data (register index) |
| bus_rdata_i | input | 8 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Bus transaction acknowledge |
| mem_wr_o | output | 1 | DRAM write request |
| mem_addr_o | output | 24 | DRAM byte address of the word |
| mem_wdata_o | output | 16 | DRAM write word |
| mem_ack_i | input | 1 | DRAM write acknowledge |
| cpu_reset_n_o | output | 1 | Processor reset, low while copying |
| cpu_halt_n_o | output | 1 | Processor halt, low while copying |
| done_o | output | 1 | Copy finished or skipped |

## Verification
On every cycle the assertions check the handshake rules. Requests stay stable until acknowledged, and done is sticky. No request appears while the processor is free, and every accepted DRAM write is followed by a cycle without a write request. Only the bench's scenarios can show that the copied content and its byte order are correct, that exactly one index write and 512 reads take place, and that done rises on the edge of the final acknowledge. The same applies to the inhibit path and to a restart after a mid-copy reset. The bench shows these against a peripheral and DRAM model with random wait states.

// File: rtl/boot_copier_pkg.sv
package boot_copier_pkg;

    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_SEL   = 3'd1,
        ST_RD_HI = 3'd2,
        ST_RD_LO = 3'd3,
        ST_WRITE = 3'd4,
        ST_DONE  = 3'd5
    } copy_state_e;

    typedef struct packed {
        copy_state_e state;
    } copy_ctl_t;

endpackage

// File: rtl/boot_pair_packer.sv
module boot_pair_packer #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_hi_i,
    input  logic                  load_lo_i,
    input  logic [BYTE_W-1:0]     byte_i,
    output logic [2*BYTE_W-1:0]   word_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } pair_t;

    pair_t pair_d, pair_q;

    always_comb begin
        pair_d = pair_q;
        if (load_hi_i) pair_d.hi = byte_i;
        if (load_lo_i) pair_d.lo = byte_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end

    assign word_o = {pair_q.hi, pair_q.lo};

endmodule

// File: rtl/boot_word_counter.sv
module boot_word_counter #(
    parameter int WORDS = 256,
    parameter int CW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    output logic [CW-1:0] count_o,
    output logic          last_o
);
    localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step_i) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign last_o  = (cnt_q == LAST);

endmodule

// File: rtl/boot_copier.sv
module boot_copier
    import boot_copier_pkg::*;
#(
    parameter int              BYTE_COUNT = 512,
    parameter int              ADDR_W     = 24,
    parameter logic [23:0]     IDX_ADDR   = 24'hF00001,
    parameter logic [23:0]     DATA_ADDR  = 24'hF00000,
    parameter logic [7:0]      FLASH_IDX  = 8'h00,
    parameter logic [23:0]     MEM_BASE   = 24'h000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inhibit_i,
    output logic              bus_cyc_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [7:0]        bus_wdata_o,
    input  logic [7:0]        bus_rdata_i,
    input  logic              bus_ack_i,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [15:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    output logic              cpu_reset_n_o,
    output logic              cpu_halt_n_o,
    output logic              done_o
);
    localparam int WORDS = BYTE_COUNT / 2;
    localparam int CW    = (WORDS > 1) ? $clog2(WORDS) : 1;

    copy_ctl_t ctl_d, ctl_q;

    logic [CW-1:0] word_idx;
    logic          last_word;
    logic [15:0]   word_data;
    logic          in_sel, in_rd_hi, in_rd_lo, in_write, in_done;
    logic          write_taken;

    assign in_sel      = (ctl_q.state == ST_SEL);
    assign in_rd_hi    = (ctl_q.state == ST_RD_HI);
    assign in_rd_lo    = (ctl_q.state == ST_RD_LO);
    assign in_write    = (ctl_q.state == ST_WRITE);
    assign in_done     = (ctl_q.state == ST_DONE);
    assign write_taken = in_write && mem_ack_i;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.state)
            ST_START: ctl_d.state = inhibit_i ? ST_DONE : ST_SEL;
            ST_SEL:   if (bus_ack_i) ctl_d.state = ST_RD_HI;
            ST_RD_HI: if (bus_ack_i) ctl_d.state = ST_RD_LO;
            ST_RD_LO: if (bus_ack_i) ctl_d.state = ST_WRITE;
            ST_WRITE: if (mem_ack_i) ctl_d.state = last_word ? ST_DONE : ST_RD_HI;
            ST_DONE:  ctl_d.state = ST_DONE;
            default:  ctl_d.state = ST_START;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_START};
        else        ctl_q <= ctl_d;
    end

    boot_word_counter #(.WORDS(WORDS), .CW(CW)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (write_taken),
        .count_o (word_idx),
        .last_o  (last_word)
    );

    boot_pair_packer #(.BYTE_W(8)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_hi_i (in_rd_hi && bus_ack_i),
        .load_lo_i (in_rd_lo && bus_ack_i),
        .byte_i    (bus_rdata_i),
        .word_o    (word_data)
    );

    always_comb begin
        bus_cyc_o   = in_sel || in_rd_hi || in_rd_lo;
        bus_we_o    = in_sel;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        if (in_sel) begin
            bus_addr_o  = ADDR_W'(IDX_ADDR);
            bus_wdata_o = FLASH_IDX;
        end else if (in_rd_hi || in_rd_lo) begin
            bus_addr_o  = ADDR_W'(DATA_ADDR);
        end
        mem_wr_o    = in_write;
        mem_addr_o  = in_write ? ADDR_W'(MEM_BASE) + ADDR_W'({word_idx, 1'b0}) : '0;
        mem_wdata_o = in_write ? word_data : '0;
    end

    assign done_o        = in_done;
    assign cpu_reset_n_o = in_done;
    assign cpu_halt_n_o  = in_done;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);                                                   // R6
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_n_o |-> !bus_cyc_o && !mem_wr_o);                           // R5
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc_o && !bus_ack_i |=> bus_cyc_o && $stable(bus_addr_o)
                                    && $stable(bus_we_o) && $stable(bus_wdata_o)); // R7
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o && !mem_ack_i |=> mem_wr_o && $stable(mem_addr_o)
                                   && $stable(mem_wdata_o));                  // R7
    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o && mem_ack_i |=> !mem_wr_o);                                 // R3
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cyc_o && mem_wr_o));                                            // R2

endmodule

// File: tb/tb_boot_copier.sv
module tb_boot_copier;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        inhibit_i = 0;
    logic        bus_cyc_o, bus_we_o;
    logic [23:0] bus_addr_o;
    logic [7:0]  bus_wdata_o;
    logic [7:0]  bus_rdata_i = 0;
    logic        bus_ack_i = 0;
    logic        mem_wr_o;
    logic [23:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic        mem_ack_i = 0;
    logic        cpu_reset_n_o, cpu_halt_n_o, done_o;

    always #4 clk = ~clk;

    boot_copier dut (.*);

    int checks = 0, errors = 0;
    int maxw = 3;
    int seed_k = 0;
    int idx_reg, ptr, idx_writes, reads, writes;
    int order_err, done_err, held_err, stab_err, rd_before_idx;
    int bwait, mwait, b_seen, m_seen;
    logic [23:0] b_addr, m_addr;
    logic        b_we;
    logic [7:0]  b_wd;
    logic [15:0] m_data;
    logic [15:0] dram [256];
    logic        done_edge_seen;

    function automatic logic [7:0] flash_byte(int i);
        int v;
        v = i * 29 + (i >> 8) * 7 + 8'h5A + seed_k * 13;
        return 8'(v) ^ 8'h33;
    endfunction

    function automatic int rnd_wait();
        return (maxw == 0) ? 0 : int'($urandom % (maxw + 1));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // peripheral and DRAM responder, acting at falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                idx_reg = 255; ptr = 0; idx_writes = 0; reads = 0; writes = 0;
                order_err = 0; done_err = 0; held_err = 0; stab_err = 0; rd_before_idx = 0;
                bus_ack_i = 0; mem_ack_i = 0; b_seen = 0; m_seen = 0;
                bwait = rnd_wait(); mwait = rnd_wait();
            end else begin
                if (cpu_reset_n_o && !done_o) held_err++;
                if (done_o && (bus_cyc_o || mem_wr_o)) held_err++;
                if (bus_ack_i) begin
                    if (b_we) begin
                        if (b_addr == 24'hF00001) idx_reg = int'(b_wd);
                        idx_writes++;
                    end else begin
                        if (b_addr != 24'hF00000) order_err++;
                        if (idx_writes == 0) rd_before_idx++;
                        reads++;
                        if (idx_reg == 0) ptr++;
                    end
                    bus_ack_i = 0; b_seen = 0; bwait = rnd_wait();
                end
                if (mem_ack_i) begin
                    if (m_addr != 24'(2 * writes)) order_err++;
                    if (writes < 256) dram[writes] = m_data;
                    writes++;
                    if ((writes == 256) != done_o) done_err++;
                    mem_ack_i = 0; m_seen = 0; mwait = rnd_wait();
                end
                if (bus_cyc_o) begin
                    if (b_seen && (bus_addr_o != b_addr || bus_we_o != b_we || bus_wdata_o != b_wd))
                        stab_err++;
                    b_seen = 1; b_addr = bus_addr_o; b_we = bus_we_o; b_wd = bus_wdata_o;
                    if (bwait == 0) begin
                        bus_ack_i = 1;
                        bus_rdata_i = (idx_reg == 0) ? flash_byte(ptr) : 8'hEE;
                    end else bwait--;
                end
                if (mem_wr_o) begin
                    if (m_seen && (mem_addr_o != m_addr || mem_wdata_o != m_data)) stab_err++;
                    m_seen = 1; m_addr = mem_addr_o; m_data = mem_wdata_o;
                    if (mwait == 0) mem_ack_i = 1;
                    else mwait--;
                end
            end
        end
    end

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        check(!done_o && !bus_cyc_o && !mem_wr_o, "R9 reset outputs idle",
              int'({done_o, bus_cyc_o, mem_wr_o}), 0);
        check(!cpu_reset_n_o && !cpu_halt_n_o, "R9 cpu held in reset",
              int'({cpu_reset_n_o, cpu_halt_n_o}), 0);
        rst_n = 1;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done_o) begin ok = 1; break; end
        end
    endtask

    task automatic verify_copy(input string tag);
        int bad = 0;
        logic [15:0] exp_w, first_bad_act, first_bad_exp;
        first_bad_act = 0; first_bad_exp = 0;
        for (int k = 0; k < 256; k++) begin
            exp_w = {flash_byte(2 * k), flash_byte(2 * k + 1)};
            if (dram[k] !== exp_w) begin
                if (bad == 0) begin first_bad_act = dram[k]; first_bad_exp = exp_w; end
                bad++;
            end
        end
        check(bad == 0, {"R3 word content ", tag}, int'(first_bad_act), int'(first_bad_exp));
        check(idx_writes == 1, {"R1 single index write ", tag}, idx_writes, 1);
        check(rd_before_idx == 0, {"R1 index before reads ", tag}, rd_before_idx, 0);
        check(reads == 512, {"R2 read count ", tag}, reads, 512);
        check(writes == 256, {"R3 write count ", tag}, writes, 256);
        check(order_err == 0, {"R3 address order ", tag}, order_err, 0);
        check(done_err == 0, {"R4 done timing ", tag}, done_err, 0);
        check(held_err == 0, {"R5 cpu held / quiet ", tag}, held_err, 0);
        check(stab_err == 0, {"R7 request stable ", tag}, stab_err, 0);
        check(cpu_reset_n_o && cpu_halt_n_o, {"R4 cpu released ", tag},
              int'({cpu_reset_n_o, cpu_halt_n_o}), 3);
    endtask

    initial begin
        bit ok;
        int rw;
        void'($urandom(32'h1F2E3D));

        // random wait states
        seed_k = 1; maxw = 3; inhibit_i = 0;
        apply_reset();
        wait_done(ok);
        check(ok, "R4 copy completes random waits", int'(ok), 1);
        verify_copy("random waits");
        repeat (20) @(negedge clk);
        check(done_o && !bus_cyc_o && !mem_wr_o, "R6 done sticky, R5 idle",
              int'({done_o, bus_cyc_o, mem_wr_o}), 4);

        // zero wait states
        seed_k = 2; maxw = 0;
        apply_reset();
        wait_done(ok);
        check(ok, "R4 copy completes zero waits", int'(ok), 1);
        verify_copy("zero waits");

        // mid-copy reset then restart
        seed_k = 3; maxw = 2;
        apply_reset();
        for (int i = 0; i < 20000 && writes < 40; i++) @(negedge clk);
        check(writes >= 40 && !done_o, "R9 partial copy in progress", writes, 40);
        apply_reset();
        check(writes == 0, "R9 model cleared", writes, 0);
        wait_done(ok);
        check(ok, "R9 restart completes", int'(ok), 1);
        verify_copy("after restart");

        // inhibit: skip copy
        seed_k = 4; maxw = 1;
        inhibit_i = 1;
        apply_reset();
        check(!done_o, "R8 done low before first edge", int'(done_o), 0);
        @(negedge clk);
        check(done_o && cpu_reset_n_o, "R8 done at first edge",
              int'({done_o, cpu_reset_n_o}), 3);
        inhibit_i = 0;
        repeat (30) @(negedge clk);
        check(idx_writes == 0 && reads == 0 && writes == 0, "R8 no transactions",
              idx_writes + reads + writes, 0);
        check(done_o, "R6 done holds after inhibit cleared", int'(done_o), 1);

        // inhibit dropping after the sample edge does not matter; a rising one later neither
        seed_k = 5; maxw = 3;
        apply_reset();
        @(negedge clk);
        inhibit_i = 1;
        wait_done(ok);
        inhibit_i = 0;
        check(ok, "R8 late inhibit ignored, copy completes", int'(ok), 1);
        verify_copy("late inhibit");

        // a few more random runs with random wait ceilings
        for (int r = 0; r < 2; r++) begin
            rw = int'($urandom % 5);
            seed_k = 6 + r; maxw = rw;
            apply_reset();
            wait_done(ok);
            check(ok, "R4 random run completes", int'(ok), 1);
            verify_copy("random run");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule